// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Target Cache and Return Stack

This block predicts the next fetch address for the front end of a pipelined core. The current fetch address is looked up in a direct-mapped, tagged target cache. A valid entry with a matching tag marks the fetched instruction as a branch. In that case the stored target becomes the next address, but only when a separate direction predictor reports the branch as taken. In every other case fetch continues at the following word, fetch_pc + 4. The target cache stores no direction state. An entry is written when the execute stage resolves a taken branch.

Procedure returns use a small circular stack of return addresses. A call pushes the address of the instruction after it: a call at 0x104 pushes 0x108. A return pops the top entry and uses it as the predicted target, and this takes priority over any target-cache hit. When a push finds the stack full, it overwrites the oldest entry. When a return finds the stack empty, it predicts fetch_pc + 4. The stack pointer and fill count are visible at the ports so that the front end can save them as a checkpoint. On a misprediction, a flush reloads that checkpoint. Stack contents are not repaired.

The prediction is combinational from the fetch address and the current state. All state updates happen at the next rising clock edge. rst_n is asynchronous and active low. The surrounding logic is expected to release it synchronously.

Top module: `btb_ras_predictor`

## Requirements
- R1: After reset every target-cache entry is invalid, ras_ptr and ras_cnt are 0, and next_pc is fetch_pc + 4 with pred_src = 0 for any fetch.
- R2: The target cache has 64 entries. The entry index is fetch_pc[7:2] and the tag is fetch_pc[31:8]. A hit requires a valid entry whose stored tag equals the tag of the fetch address, so an address that shares an index but has a different tag misses.
- R3: On a hit with fetch_valid high, is_ret low and pred_taken high, next_pc is the stored target and pred_src = 1.
- R4: On a hit with pred_taken low, on a miss, or when fetch_valid is low, next_pc = fetch_pc + 4 and pred_src = 0.
- R5: When upd_valid is high, the entry at upd_pc's index gets a valid bit, upd_pc's tag and upd_target. The entry is visible to lookups from the next cycle on and replaces any earlier entry at that index.
- R6: A call (fetch_valid and is_call high, is_ret low, flush low) writes fetch_pc + 4 at slot ras_ptr. It then increments ras_ptr modulo the depth (8) and increments ras_cnt, saturating at 8.
- R7: A return (fetch_valid and is_ret high) with ras_cnt > 0 predicts the most recently pushed address with pred_src = 2, even when the target cache hits. It then decrements ras_ptr and ras_cnt.
- R8: A return with ras_cnt = 0 predicts fetch_pc + 4 with pred_src = 0 and leaves ras_ptr and ras_cnt unchanged.
- R9: When more than 8 calls are pushed without returns, the oldest addresses are overwritten. The following returns yield the 8 most recent addresses, newest first, and then the empty-stack behaviour of R8.
- R10: flush loads ras_ptr from flush_ptr and ras_cnt from flush_cnt (values above 8 become 8). Any push or pop in the same cycle is discarded, and the stack contents are kept.
- R11: With is_call and is_ret both high the instruction is handled only as a return. With fetch_valid low, is_call and is_ret have no effect on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | 32 | Current fetch address |
| pred_taken | input | 1 | Taken prediction from the direction predictor |
| is_call | input | 1 | Fetched instruction is a call |
| is_ret | input | 1 | Fetched instruction is a return |
| upd_valid | input | 1 | Resolved taken branch writes the target cache |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target address |
| flush | input | 1 | Misprediction: reload stack checkpoint |
| flush_ptr | input | 3 | Checkpointed stack pointer |
| flush_cnt | input | 4 | Checkpointed stack fill count |
| next_pc | output | 32 | Predicted next fetch address |
| pred_src | output | 2 | Source of next_pc: 0 sequential, 1 target cache, 2 return stack |
| ras_ptr | output | 3 | Current stack pointer, for checkpointing |
| ras_cnt | output | 4 | Current stack fill count, for checkpointing |

## Verification
The assertions check the following properties on every cycle:
- a not-taken or invalid fetch that is not a return always gets the sequential address;
- a target written in one cycle is predicted in the next cycle for the same address;
- a return right after a call predicts the call's address + 4;
- the fill count steps by one on each push or pop, never exceeds the depth, and an empty stack never sources a prediction;
- a flush loads the checkpoint pointer.

Some behaviours need longer histories, and only the bench scenarios can show them: tag aliasing and eviction at a shared index, wrap-around overwriting of the oldest return address after more than eight calls, newest-first ordering across deep nesting, and stack contents surviving a checkpoint restore.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BTB = 2'd1,
    SRC_RAS = 2'd2
  } src_e;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-3:0] lk_word,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  input  logic            wr_en,
  input  logic [PC_W-3:0] wr_word,
  input  logic [PC_W-1:0] wr_target
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;

  assign lk_idx = lk_word[IDX_W-1:0];
  assign lk_tag = lk_word[PC_W-3:IDX_W];
  assign wr_idx = wr_word[IDX_W-1:0];
  assign wr_tag = wr_word[PC_W-3:IDX_W];

  // Lookup sees the state before this cycle's write.
  assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_target = tgt_q[lk_idx];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic wr_this;
    assign wr_this = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (wr_this) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_target;
      end
    end
  end
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [PC_W-1:0]            push_addr,
  input  logic                       pop,
  input  logic                       restore,
  input  logic [$clog2(DEPTH)-1:0]   restore_ptr,
  input  logic [$clog2(DEPTH+1)-1:0] restore_cnt,
  output logic [PC_W-1:0]            top_addr,
  output logic                       empty,
  output logic [$clog2(DEPTH)-1:0]   ptr_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_pop, do_push;

  assign empty    = (cnt_q == '0);
  assign top_addr = mem_q[ptr_q - PTR_W'(1)];
  assign ptr_o    = ptr_q;
  assign cnt_o    = cnt_q;
  assign do_pop   = pop && !empty && !restore;
  assign do_push  = push && !pop && !restore;

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (restore) begin
      ptr_d = restore_ptr;
      cnt_d = (restore_cnt > FULL) ? FULL : restore_cnt;
    end else if (do_pop) begin
      ptr_d = ptr_q - PTR_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end else if (do_push) begin
      ptr_d = ptr_q + PTR_W'(1);
      if (cnt_q != FULL) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic wr_this;
    assign wr_this = do_push && (ptr_q == PTR_W'(s));
    always_ff @(posedge clk) begin
      if (wr_this) mem_q[s] <= push_addr;
    end
  end
endmodule

// File: rtl/btb_ras_predictor.sv
module btb_ras_predictor #(
  parameter int PC_W        = 32,
  parameter int BTB_ENTRIES = 64,
  parameter int RAS_DEPTH   = 8,
  localparam int PTR_W      = $clog2(RAS_DEPTH),
  localparam int CNT_W      = $clog2(RAS_DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             pred_taken,
  input  logic             is_call,
  input  logic             is_ret,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [PC_W-1:0]  upd_target,
  input  logic             flush,
  input  logic [PTR_W-1:0] flush_ptr,
  input  logic [CNT_W-1:0] flush_cnt,
  output logic [PC_W-1:0]  next_pc,
  output logic [1:0]       pred_src,
  output logic [PTR_W-1:0] ras_ptr,
  output logic [CNT_W-1:0] ras_cnt
);
  import bpred_pkg::*;

  logic            hit;
  logic [PC_W-1:0] hit_target, seq_pc, ras_top;
  logic            ras_empty, ret_act, call_act;
  src_e            src;

  assign seq_pc   = fetch_pc + PC_W'(4);
  assign ret_act  = fetch_valid && is_ret;
  assign call_act = fetch_valid && is_call && !is_ret;

  btb_table #(.PC_W(PC_W), .ENTRIES(BTB_ENTRIES)) u_btb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_word   (fetch_pc[PC_W-1:2]),
    .lk_hit    (hit),
    .lk_target (hit_target),
    .wr_en     (upd_valid),
    .wr_word   (upd_pc[PC_W-1:2]),
    .wr_target (upd_target)
  );

  ras_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (call_act),
    .push_addr   (seq_pc),
    .pop         (ret_act),
    .restore     (flush),
    .restore_ptr (flush_ptr),
    .restore_cnt (flush_cnt),
    .top_addr    (ras_top),
    .empty       (ras_empty),
    .ptr_o       (ras_ptr),
    .cnt_o       (ras_cnt)
  );

  // Return stack first, then taken target-cache hit, else sequential.
  always_comb begin
    src     = SRC_SEQ;
    next_pc = seq_pc;
    if (ret_act) begin
      if (!ras_empty) begin
        src     = SRC_RAS;
        next_pc = ras_top;
      end
    end else if (fetch_valid && hit && pred_taken) begin
      src     = SRC_BTB;
      next_pc = hit_target;
    end
  end

  assign pred_src = src;
endmodule

// File: rtl/btb_ras_predictor_chk.sv
module btb_ras_predictor_chk #(
  parameter int PC_W      = 32,
  parameter int RAS_DEPTH = 8,
  localparam int PTR_W    = $clog2(RAS_DEPTH),
  localparam int CNT_W    = $clog2(RAS_DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             pred_taken,
  input logic             is_call,
  input logic             is_ret,
  input logic             upd_valid,
  input logic [PC_W-1:0]  upd_pc,
  input logic [PC_W-1:0]  upd_target,
  input logic             flush,
  input logic [PTR_W-1:0] flush_ptr,
  input logic [CNT_W-1:0] flush_cnt,
  input logic [PC_W-1:0]  next_pc,
  input logic [1:0]       pred_src,
  input logic [PTR_W-1:0] ras_ptr,
  input logic [CNT_W-1:0] ras_cnt
);
  // R4
  seq_when_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ret && (!fetch_valid || !pred_taken)) |-> (next_pc == fetch_pc + PC_W'(4) && pred_src == 2'd0));

  // R5
  update_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (!(fetch_valid && !is_ret && pred_taken && fetch_pc == $past(upd_pc))
                   || next_pc == $past(upd_target)));

  // R6
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && is_call && !is_ret && !flush && ras_cnt != CNT_W'(RAS_DEPTH))
      |=> ras_cnt == $past(ras_cnt) + CNT_W'(1));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_cnt <= CNT_W'(RAS_DEPTH));

  // R7
  call_then_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && is_call && !is_ret && !flush)
      |=> (!(fetch_valid && is_ret) || (next_pc == $past(fetch_pc) + PC_W'(4) && pred_src == 2'd2)));

  // R7
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && is_ret && ras_cnt != '0 && !flush) |=> ras_cnt == $past(ras_cnt) - CNT_W'(1));

  // R8
  empty_no_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_cnt == '0) |-> pred_src != 2'd2);

  // R10
  flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ras_ptr == $past(flush_ptr));
endmodule

bind btb_ras_predictor btb_ras_predictor_chk #(.PC_W(PC_W), .RAS_DEPTH(RAS_DEPTH)) u_chk (.*);

// File: tb/btb_ras_predictor_bench.sv
module btb_ras_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, pred_taken, is_call, is_ret, upd_valid, flush;
  logic [31:0] fetch_pc, upd_pc, upd_target;
  logic [2:0]  flush_ptr;
  logic [3:0]  flush_cnt;
  logic [31:0] next_pc;
  logic [1:0]  pred_src;
  logic [2:0]  ras_ptr;
  logic [3:0]  ras_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  bit          m_v   [64];
  logic [23:0] m_tag [64];
  logic [31:0] m_tgt [64];
  logic [31:0] m_stk [8];
  int          m_ptr, m_cnt;

  always #10 clk = ~clk;

  btb_ras_predictor u_btb_ras_predictor (.*);

  task automatic model_predict(output logic [31:0] pc, output int src);
    int i;
    i   = int'(fetch_pc[7:2]);
    pc  = fetch_pc + 32'd4;
    src = 0;
    if (fetch_valid && is_ret) begin
      if (m_cnt > 0) begin
        pc  = m_stk[(m_ptr + 7) % 8];
        src = 2;
      end
    end else if (fetch_valid && pred_taken && m_v[i] && m_tag[i] == fetch_pc[31:8]) begin
      pc  = m_tgt[i];
      src = 1;
    end
  endtask

  task automatic model_update();
    int i;
    if (upd_valid) begin
      i = int'(upd_pc[7:2]);
      m_v[i]   = 1'b1;
      m_tag[i] = upd_pc[31:8];
      m_tgt[i] = upd_target;
    end
    if (flush) begin
      m_ptr = int'(flush_ptr);
      m_cnt = (int'(flush_cnt) > 8) ? 8 : int'(flush_cnt);
    end else if (fetch_valid && is_ret) begin
      if (m_cnt > 0) begin
        m_ptr = (m_ptr + 7) % 8;
        m_cnt--;
      end
    end else if (fetch_valid && is_call) begin
      m_stk[m_ptr] = fetch_pc + 32'd4;
      m_ptr = (m_ptr + 1) % 8;
      if (m_cnt < 8) m_cnt++;
    end
  endtask

  task automatic compare(input string req);
    logic [31:0] epc;
    int esrc;
    model_predict(epc, esrc);
    checks++;
    if (next_pc !== epc || int'(pred_src) != esrc || int'(ras_ptr) != m_ptr || int'(ras_cnt) != m_cnt) begin
      errors++;
      $display("FAIL %s: next_pc=%h src=%0d ptr=%0d cnt=%0d expected next_pc=%h src=%0d ptr=%0d cnt=%0d",
               req, next_pc, pred_src, ras_ptr, ras_cnt, epc, esrc, m_ptr, m_cnt);
    end
  endtask

  // Drive at negedge, compare, then let the edge update both sides.
  task automatic step(input bit fv, input logic [31:0] pc, input bit pt, input bit call,
                      input bit ret, input string req);
    fetch_valid = fv; fetch_pc = pc; pred_taken = pt; is_call = call; is_ret = ret;
    #1;
    compare(req);
    @(posedge clk);
    model_update();
    @(negedge clk);
    upd_valid = 0; flush = 0;
  endtask

  task automatic learn(input logic [31:0] pc, input logic [31:0] tgt, input string req);
    upd_valid = 1; upd_pc = pc; upd_target = tgt;
    step(0, 32'h0, 0, 0, 0, req);
  endtask

  initial begin
    rst_n = 0; fetch_valid = 0; fetch_pc = 0; pred_taken = 0; is_call = 0; is_ret = 0;
    upd_valid = 0; upd_pc = 0; upd_target = 0; flush = 0; flush_ptr = 0; flush_cnt = 0;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    m_ptr = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    #1; compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    step(1, 32'h0000_1000, 1, 0, 0, "R1 empty cache");
    step(1, 32'h0000_2004, 0, 0, 1, "R1 empty stack");

    // Target cache
    learn(32'h0000_1000, 32'h0000_2000, "R5 write");
    step(1, 32'h0000_1000, 1, 0, 0, "R3 taken hit");
    step(1, 32'h0000_1000, 0, 0, 0, "R4 not-taken hit");
    step(1, 32'h0000_1004, 1, 0, 0, "R4 miss");
    step(0, 32'h0000_1000, 1, 0, 0, "R4 no fetch");
    step(1, 32'h0000_1100, 1, 0, 0, "R2 alias tag differs");
    learn(32'h0000_1100, 32'h0000_3000, "R5 alias write");
    step(1, 32'h0000_1100, 1, 0, 0, "R5 alias hit");
    step(1, 32'h0000_1000, 1, 0, 0, "R5 evicted miss");
    learn(32'h0000_0128, 32'h0000_5550, "R5 write at return pc");

    // Return stack
    step(1, 32'h0000_0104, 0, 1, 0, "R6 push 0x108");
    step(1, 32'h0000_0124, 0, 1, 0, "R6 push 0x128");
    step(1, 32'h0000_0128, 1, 0, 1, "R7 pop over cache hit");
    step(1, 32'h0000_010c, 0, 0, 1, "R7 pop 0x108");
    step(1, 32'h0000_0128, 1, 0, 1, "R8 empty return");
    step(1, 32'h0000_0300, 0, 1, 1, "R11 call+ret as return");
    step(0, 32'h0000_0300, 0, 1, 0, "R11 call without fetch");
    step(1, 32'h0000_0400, 0, 0, 1, "R11 stack untouched");

    // Overflow
    for (int k = 0; k < 10; k++) step(1, 32'h0000_8000 + 32'(k * 16), 0, 1, 0, "R9 push");
    for (int k = 0; k < 9; k++)  step(1, 32'h0000_9000, 0, 0, 1, "R9 pop newest first");

    // Checkpoint restore
    for (int k = 0; k < 3; k++) step(1, 32'h0000_a000 + 32'(k * 8), 0, 1, 0, "R10 fill");
    flush = 1; flush_ptr = 3'(m_ptr - 2); flush_cnt = 4'(m_cnt - 2);
    step(1, 32'h0000_b000, 0, 1, 0, "R10 flush drops push");
    step(1, 32'h0000_b100, 0, 0, 1, "R10 contents kept");
    flush = 1; flush_ptr = 3'd5; flush_cnt = 4'd15;
    step(1, 32'h0000_b200, 0, 0, 1, "R10 flush drops pop");
    step(1, 32'h0000_b300, 0, 0, 0, "R10 count clamped");

    // Mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pc;
      pc = {22'h0, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), 2'b00};
      if ($urandom_range(0, 5) == 0) begin
        upd_valid = 1;
        upd_pc = {22'h0, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), 2'b00};
        upd_target = $urandom & 32'hffff_fffc;
      end
      if ($urandom_range(0, 40) == 0) begin
        flush = 1; flush_ptr = 3'($urandom); flush_cnt = 4'($urandom_range(0, 8));
      end
      step($urandom_range(0, 7) != 0, pc, 1'($urandom), $urandom_range(0, 4) == 0,
           $urandom_range(0, 4) == 0, "R3 R6 R7 mixed");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule